// File: doc/BRIEF.md
# Protection-Checking Tagged Translation Buffer

This block is a small, fully associative address translation cache. Each slot maps a virtual page number to a physical frame number. The slot is tagged with a process identifier and carries read, write and execute permissions, a modified flag and a private flag. A requester presents a process id, a virtual page number, a page offset, an access kind and a supervisor flag. One cycle later the block answers with exactly one of three outcomes:

- a hit, which returns the physical address (frame number followed by the unchanged offset);
- an access fault, which returns no address;
- a miss, which the surrounding logic treats as a page-table lookup or a page fault.

New translations arrive through a refill port. On a context switch, software may discard every slot, or only the private slots of one process. Shared slots serve every process. A supervisor may write to, or execute from, a shared page regardless of its write and execute permissions. When every slot is occupied, a refill replaces a pseudo-randomly chosen slot.

Top module: `prot_tlb`

## Requirements
- R1: A permitted lookup that matches a slot raises `rsp_hit` in the cycle after `lk_valid`, with `rsp_paddr` = {frame, `lk_off`}.
- R2: A slot filled with `fill_priv`=1 matches only a lookup whose process id equals its own. A slot filled with `fill_priv`=0 matches any process id.
- R3: The access code is 0 = read, 1 = write, 2 = execute, 3 = reserved and never permitted. The permission field is bit 2 = read, bit 1 = write, bit 0 = execute. In user mode (`lk_sup`=0) a matched lookup whose permission bit is clear raises `rsp_fault` with `rsp_paddr` = 0.
- R4: With `lk_sup`=1, a write or execute to a shared slot is permitted whatever its write and execute bits are. A read still needs the read bit, and private slots obey their permission bits in both modes.
- R5: `rsp_mod` reports the modified flag that the matched slot held before the lookup. A permitted write sets it. A faulting write leaves it clear.
- R6: A lookup that matches no valid slot raises `rsp_miss` with `rsp_paddr` = 0.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and in that cycle exactly one of `rsp_hit`, `rsp_fault`, `rsp_miss` is set. In all other cycles all four are low.
- R8: After a cycle with `flush_all` high, every lookup misses until the next refill.
- R9: `flush_pid_valid` invalidates only the private slots whose process id equals `flush_pid`. Shared slots and other processes' slots stay.
- R10: A refill goes to the lowest-numbered invalid slot. When all slots are valid, it replaces exactly one slot, chosen pseudo-randomly, and the new slot starts with its modified flag clear.
- R11: After reset all slots are invalid and all response outputs are low.
- R12: When several slots match, the lowest-numbered one answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | PID_W | Requesting process id |
| lk_vpn | input | VPN_W | Virtual page number |
| lk_off | input | OFF_W | Page offset |
| lk_acc | input | 2 | Access code (0 read, 1 write, 2 execute) |
| lk_sup | input | 1 | 1 = supervisor mode |
| fill_valid | input | 1 | Refill request |
| fill_pid | input | PID_W | Process id of new slot |
| fill_vpn | input | VPN_W | Virtual page of new slot |
| fill_pfn | input | PFN_W | Frame number of new slot |
| fill_perm | input | 3 | Permissions {read, write, execute} |
| fill_priv | input | 1 | 1 = private to `fill_pid` |
| flush_all | input | 1 | Invalidate every slot |
| flush_pid_valid | input | 1 | Invalidate private slots of `flush_pid` |
| flush_pid | input | PID_W | Process id to purge |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | Access not permitted |
| rsp_miss | output | 1 | No matching slot |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on hit, else 0 |
| rsp_mod | output | 1 | Modified flag of matched slot before this lookup |

## Verification
The bench aims at the cases where the process tag and the permission check interact:

- **Shared versus private.** A shared slot must be reachable from a foreign process, a private one must not. A design that ignored the private flag would hit for the wrong process.
- **Supervisor override.** Supervisor writes and fetches to a read-only shared page must be granted, while the same writes to a private page and reads without the read bit must still fault. A design that applied the override too broadly would grant them.
- **Priority between overlapping slots.** A private and a shared slot for the same page are resolved by slot order, and purging the process then exposes the shared frame.
- **Modified flag.** A faulting write must leave the flag clear, and a permitted write must set it.
- **Replacement when full.** A refill into a full buffer must displace exactly one old translation. A victim selector that ignored free slots, or cleared several, would show up as extra misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    // Supervisor may store/fetch on shared pages regardless of wr/ex.
    function automatic logic access_allowed(acc_e acc, perm_t perm,
                                            logic sup, logic priv);
        logic bypass;
        bypass = sup && !priv;
        case (acc)
            ACC_LOAD:  access_allowed = perm.rd;
            ACC_STORE: access_allowed = perm.wr || bypass;
            ACC_FETCH: access_allowed = perm.ex || bypass;
            default:   access_allowed = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int W     = 8,
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] pick
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= {{(W-1){1'b0}}, 1'b1};
        else     q <= {q[W-2:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    end

    assign pick = q[OUT_W-1:0];
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 8,
    parameter int PID_W = 4,
    parameter int VPN_W = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0]            priv,
    input  logic [N-1:0][PID_W-1:0] pid,
    input  logic [N-1:0][VPN_W-1:0] vpn,
    input  logic [PID_W-1:0]        q_pid,
    input  logic [VPN_W-1:0]        q_vpn,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (vpn[g] == q_vpn) &&
                          (!priv[g] || (pid[g] == q_pid));
    end

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] slot
);
    logic             has_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        slot = has_free ? free_idx : rnd;
    end
endmodule

// File: rtl/prot_tlb.sv
module prot_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PID_W   = 4,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 8,
    parameter int OFF_W   = 4,
    parameter int LFSR_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_valid,
    input  logic [PID_W-1:0]       lk_pid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [OFF_W-1:0]       lk_off,
    input  logic [1:0]             lk_acc,
    input  logic                   lk_sup,
    input  logic                   fill_valid,
    input  logic [PID_W-1:0]       fill_pid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PFN_W-1:0]       fill_pfn,
    input  logic [2:0]             fill_perm,
    input  logic                   fill_priv,
    input  logic                   flush_all,
    input  logic                   flush_pid_valid,
    input  logic [PID_W-1:0]       flush_pid,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_fault,
    output logic                   rsp_miss,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   rsp_mod
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int PA_W  = PFN_W + OFF_W;

    logic [ENTRIES-1:0]            e_valid;
    logic [ENTRIES-1:0]            e_priv;
    logic [ENTRIES-1:0]            e_mod;
    logic [ENTRIES-1:0][PID_W-1:0] e_pid;
    logic [ENTRIES-1:0][VPN_W-1:0] e_vpn;
    logic [ENTRIES-1:0][PFN_W-1:0] e_pfn;
    perm_t [ENTRIES-1:0]           e_perm;

    logic             m_any;
    logic [IDX_W-1:0] m_idx;
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] fill_idx;
    logic             grant;
    logic             do_hit;
    acc_e             acc;

    tlb_cam #(.N(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_cam (
        .valid (e_valid),
        .priv  (e_priv),
        .pid   (e_pid),
        .vpn   (e_vpn),
        .q_pid (lk_pid),
        .q_vpn (lk_vpn),
        .any   (m_any),
        .idx   (m_idx)
    );

    tlb_lfsr #(.W(LFSR_W), .OUT_W(IDX_W)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .pick (rnd_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid (e_valid),
        .rnd   (rnd_idx),
        .slot  (fill_idx)
    );

    assign acc    = acc_e'(lk_acc);
    assign grant  = access_allowed(acc, e_perm[m_idx], lk_sup, e_priv[m_idx]);
    assign do_hit = lk_valid && m_any && grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid   <= '0;
            e_mod     <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
            rsp_mod   <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= do_hit;
            rsp_fault <= lk_valid && m_any && !grant;
            rsp_miss  <= lk_valid && !m_any;
            rsp_paddr <= do_hit ? {e_pfn[m_idx], lk_off} : PA_W'(0);
            rsp_mod   <= lk_valid && m_any && e_mod[m_idx];

            if (do_hit && acc == ACC_STORE)
                e_mod[m_idx] <= 1'b1;

            if (flush_all) begin
                e_valid <= '0;
            end else if (flush_pid_valid) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (e_priv[i] && e_pid[i] == flush_pid)
                        e_valid[i] <= 1'b0;
            end

            if (fill_valid) begin
                e_valid[fill_idx] <= 1'b1;
                e_mod[fill_idx]   <= 1'b0;
                e_priv[fill_idx]  <= fill_priv;
                e_pid[fill_idx]   <= fill_pid;
                e_vpn[fill_idx]   <= fill_vpn;
                e_pfn[fill_idx]   <= fill_pfn;
                e_perm[fill_idx]  <= perm_t'(fill_perm);
            end
        end
    end
endmodule

// File: rtl/tlb_props.sv
module tlb_props #(
    parameter int PA_W  = 12,
    parameter int OFF_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [OFF_W-1:0] lk_off,
    input logic [1:0]      lk_acc,
    input logic            flush_all,
    input logic            fill_valid,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic            rsp_miss,
    input logic [PA_W-1:0] rsp_paddr
);
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1);

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit && !rsp_fault && !rsp_miss);

    p_answer_next_r7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_off)));

    p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_paddr == '0);

    p_miss_no_addr_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> rsp_paddr == '0);

    p_reserved_denied_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_acc == 2'd3) |=> !rsp_hit);

    p_flush_then_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !fill_valid) |=> (lk_valid |=> rsp_miss));
endmodule

bind prot_tlb tlb_props #(.PA_W(PFN_W + OFF_W), .OFF_W(OFF_W)) u_props (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_off     (lk_off),
    .lk_acc     (lk_acc),
    .flush_all  (flush_all),
    .fill_valid (fill_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_miss   (rsp_miss),
    .rsp_paddr  (rsp_paddr)
);

// File: tb/prot_tlb_test.sv
module prot_tlb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0;
    logic [3:0]  lk_pid = 0;
    logic [7:0]  lk_vpn = 0;
    logic [3:0]  lk_off = 0;
    logic [1:0]  lk_acc = 0;
    logic        lk_sup = 0;
    logic        fill_valid = 0;
    logic [3:0]  fill_pid = 0;
    logic [7:0]  fill_vpn = 0;
    logic [7:0]  fill_pfn = 0;
    logic [2:0]  fill_perm = 0;
    logic        fill_priv = 0;
    logic        flush_all = 0;
    logic        flush_pid_valid = 0;
    logic [3:0]  flush_pid = 0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_mod;
    logic [11:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prot_tlb uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_acc(lk_acc), .lk_sup(lk_sup),
        .fill_valid(fill_valid), .fill_pid(fill_pid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_priv(fill_priv),
        .flush_all(flush_all), .flush_pid_valid(flush_pid_valid), .flush_pid(flush_pid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .rsp_mod(rsp_mod)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // outcome encoding for checks: {hit,fault,miss,paddr}
    task automatic expect_rsp(input string req, input logic h, input logic f,
                              input logic m, input logic [11:0] pa);
        check(req, {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_paddr},
                   {1'b1, h, f, m, pa});
    endtask

    task automatic lookup(input logic [3:0] pid, input logic [7:0] vpn,
                          input logic [3:0] off, input logic [1:0] acc, input logic sup);
        lk_valid = 1; lk_pid = pid; lk_vpn = vpn; lk_off = off; lk_acc = acc; lk_sup = sup;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic fill(input logic [3:0] pid, input logic [7:0] vpn, input logic [7:0] pfn,
                        input logic [2:0] perm, input logic priv);
        fill_valid = 1; fill_pid = pid; fill_vpn = vpn; fill_pfn = pfn;
        fill_perm = perm; fill_priv = priv;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic t_reset;
        check("R11 idle outputs", {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_mod, rsp_paddr}, 0);
        lookup(4'd0, 8'h00, 4'd0, 2'd0, 1'b0);
        expect_rsp("R11 empty buffer misses", 0, 0, 1, 12'h0);
        @(negedge clk);
        check("R7 no response without request", {rsp_valid, rsp_hit, rsp_fault, rsp_miss}, 0);
    endtask

    task automatic t_basic;
        fill(4'd1, 8'h10, 8'hA5, 3'b111, 1'b1);
        lookup(4'd1, 8'h10, 4'd3, 2'd0, 1'b0);
        expect_rsp("R1 read hit", 1, 0, 0, 12'hA53);
        lookup(4'd2, 8'h10, 4'd3, 2'd0, 1'b0);
        expect_rsp("R2 private foreign pid", 0, 0, 1, 12'h0);
        lookup(4'd1, 8'h11, 4'd3, 2'd0, 1'b0);
        expect_rsp("R6 unmapped page", 0, 0, 1, 12'h0);
    endtask

    task automatic t_shared;
        fill(4'd7, 8'h20, 8'h3C, 3'b100, 1'b0);
        lookup(4'd9, 8'h20, 4'd5, 2'd0, 1'b0);
        expect_rsp("R2 shared any pid", 1, 0, 0, 12'h3C5);
        lookup(4'd9, 8'h20, 4'd5, 2'd1, 1'b0);
        expect_rsp("R3 user write denied", 0, 1, 0, 12'h0);
        lookup(4'd9, 8'h20, 4'd5, 2'd2, 1'b0);
        expect_rsp("R3 user exec denied", 0, 1, 0, 12'h0);
        lookup(4'd9, 8'h20, 4'd5, 2'd3, 1'b1);
        expect_rsp("R3 reserved code denied", 0, 1, 0, 12'h0);
        lookup(4'd9, 8'h20, 4'd6, 2'd1, 1'b1);
        expect_rsp("R4 sup write shared", 1, 0, 0, 12'h3C6);
        lookup(4'd9, 8'h20, 4'd7, 2'd2, 1'b1);
        expect_rsp("R4 sup exec shared", 1, 0, 0, 12'h3C7);
    endtask

    task automatic t_priv_sup;
        fill(4'd2, 8'h30, 8'h44, 3'b100, 1'b1);
        lookup(4'd2, 8'h30, 4'd0, 2'd1, 1'b1);
        expect_rsp("R4 sup write private denied", 0, 1, 0, 12'h0);
        fill(4'd2, 8'h31, 8'h45, 3'b011, 1'b0);
        lookup(4'd5, 8'h31, 4'd0, 2'd0, 1'b1);
        expect_rsp("R4 sup read needs R", 0, 1, 0, 12'h0);
    endtask

    task automatic t_modified;
        lookup(4'd1, 8'h10, 4'd0, 2'd0, 1'b0);
        check("R5 clean before write", rsp_mod, 0);
        lookup(4'd1, 8'h10, 4'd1, 2'd1, 1'b0);
        expect_rsp("R5 write hit", 1, 0, 0, 12'hA51);
        lookup(4'd1, 8'h10, 4'd0, 2'd0, 1'b0);
        check("R5 modified after write", rsp_mod, 1);
        fill(4'd1, 8'h40, 8'h60, 3'b100, 1'b1);
        lookup(4'd1, 8'h40, 4'd0, 2'd1, 1'b0);
        expect_rsp("R5 faulting write", 0, 1, 0, 12'h0);
        lookup(4'd1, 8'h40, 4'd0, 2'd0, 1'b0);
        check("R5 faulting write leaves clean", rsp_mod, 0);
    endtask

    task automatic t_overlap;
        fill(4'd3, 8'h50, 8'h11, 3'b111, 1'b1);
        fill(4'd0, 8'h50, 8'h22, 3'b111, 1'b0);
        lookup(4'd3, 8'h50, 4'd2, 2'd0, 1'b0);
        expect_rsp("R12 lower slot wins", 1, 0, 0, 12'h112);
        lookup(4'd4, 8'h50, 4'd2, 2'd0, 1'b0);
        expect_rsp("R12 shared for other pid", 1, 0, 0, 12'h222);
    endtask

    task automatic t_flush_pid;
        flush_pid_valid = 1; flush_pid = 4'd3;
        @(negedge clk);
        flush_pid_valid = 0;
        lookup(4'd3, 8'h50, 4'd2, 2'd0, 1'b0);
        expect_rsp("R9 private purged, shared seen", 1, 0, 0, 12'h222);
        lookup(4'd1, 8'h10, 4'd2, 2'd0, 1'b0);
        expect_rsp("R9 other pid kept", 1, 0, 0, 12'hA52);
        lookup(4'd3, 8'h20, 4'd2, 2'd0, 1'b0);
        expect_rsp("R9 shared kept", 1, 0, 0, 12'h3C2);
    endtask

    task automatic t_flush_all;
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
        lookup(4'd1, 8'h10, 4'd0, 2'd0, 1'b0);
        expect_rsp("R8 private gone", 0, 0, 1, 12'h0);
        lookup(4'd1, 8'h20, 4'd0, 2'd0, 1'b0);
        expect_rsp("R8 shared gone", 0, 0, 1, 12'h0);
    endtask

    task automatic t_full;
        int misses;
        for (int i = 0; i < 8; i++) fill(4'd0, 8'h60 + 8'(i), 8'h80 + 8'(i), 3'b111, 1'b1);
        for (int i = 0; i < 8; i++) begin
            lookup(4'd0, 8'h60 + 8'(i), 4'd0, 2'd0, 1'b0);
            expect_rsp("R10 free slots used first", 1, 0, 0, {8'h80 + 8'(i), 4'd0});
        end
        lookup(4'd0, 8'h62, 4'd0, 2'd1, 1'b0);
        fill(4'd0, 8'h70, 8'hEE, 3'b111, 1'b1);
        lookup(4'd0, 8'h70, 4'd9, 2'd0, 1'b0);
        expect_rsp("R10 refill into full buffer", 1, 0, 0, 12'hEE9);
        check("R10 new slot clean", rsp_mod, 0);
        misses = 0;
        for (int i = 0; i < 8; i++) begin
            lookup(4'd0, 8'h60 + 8'(i), 4'd0, 2'd0, 1'b0);
            if (rsp_miss) misses++;
        end
        check("R10 exactly one victim", misses, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_shared;
        t_priv_sup;
        t_modified;
        t_overlap;
        t_flush_pid;
        t_flush_all;
        t_full;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule